// File: doc/BRIEF.md
# Linear CCD Drive Clock Generator

This block derives every drive clock that a three-channel linear CCD sensor needs from one system clock. Each line begins with a transfer window. The first shift clock is parked high. After a setup gap the shared transfer-gate pulse rises, stays high for a fixed time, then falls. A hold gap follows before shifting resumes. After the window, the two complementary shift clocks run at the pixel rate. Inside each pixel period the block places a short charge-node reset pulse and, later in the same period, a clamp pulse. The red, green and blue transfer gates all take the single gate output, so they fire together.

All times are parameters counted in system-clock cycles: pixel period, the position and width of the two sub-pulses, setup, gate and hold, and the full line period, which sets the integration time. The defaults assume a 20 MHz system clock. That gives a 1 MHz pixel rate, a 100 ns setup, a 5 us gate, a 1.9 us hold, a 50 ns reset pulse, a 100 ns clamp pulse and a 5.5 ms line. Downstream sampling logic receives a one-cycle line-start strobe, a pixel-valid qualifier and a 1-based pixel index. The sensor cannot be stalled, so the pixel stream has no ready input and no back-pressure: a consumer must accept every valid cycle. The shift clocks keep running after the last counted pixel until the next window. This gives the sensor at least the required number of transfer cycles per line.

All outputs come from registers. They reflect the internal line position one clock after that position is reached.

Top module: `ccd_clkgen`

## Requirements
- R1: While rst_n is low, and on the first clock edge of a reset, shift_a=1, shift_b=0, and xfer_gate, node_rst, clamp, line_start and pixel_valid are 0, with pixel_index=0.
- R2: shift_b is always the complement of shift_a.
- R3: xfer_gate is high for exactly GATE_CLKS consecutive cycles once per line, and lines repeat every LINE_CLKS cycles.
- R4: shift_a is high for SETUP_CLKS cycles before xfer_gate rises, throughout the gate, and for HOLD_CLKS cycles after it falls. During this whole window node_rst and clamp stay low.
- R5: After the window, each pixel period lasts PIX_CLKS cycles. shift_a is high for the first PIX_CLKS/2 cycles of the period and low for the rest.
- R6: node_rst is high in pixel-period offsets RST_AT to RST_AT+RST_LEN-1. Offset 0 is the cycle where shift_a rises.
- R7: clamp is high in offsets CLP_AT to CLP_AT+CLP_LEN-1. It is never high in the same cycle as node_rst.
- R8: pixel_valid is high for exactly NUM_PIX*PIX_CLKS consecutive cycles per line, starting in the first cycle after the window. It is never high while xfer_gate is high.
- R9: pixel_index is the 1-based number of the current pixel (1 to NUM_PIX) while pixel_valid is high. It is 0 otherwise.
- R10: line_start is a single-cycle pulse in the first cycle of pixel 1, once per line.
- R11: A reset asserted mid-line restarts the line from the start of the setup gap after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_a | output | 1 | First transfer (shift) clock |
| shift_b | output | 1 | Complementary transfer clock |
| xfer_gate | output | 1 | Transfer-gate pulse shared by the R, G and B gates |
| node_rst | output | 1 | Per-pixel output-node reset pulse |
| clamp | output | 1 | Per-pixel clamp pulse |
| line_start | output | 1 | One-cycle strobe at the first cycle of pixel 1 |
| pixel_valid | output | 1 | High while a counted pixel is being shifted out |
| pixel_index | output | $clog2(NUM_PIX+1) | 1-based pixel number, 0 when not valid |

## Verification
The hardest events to reach are the transition from the last counted pixel into the free-running tail, and the wrap of the tail back into the next transfer window. With the default pixel count and line length these happen only once every 110,000 cycles. The bench therefore scales the parameters down to ten pixels of eight cycles and a 112-cycle line. It then compares every output against a cycle model across three whole lines, which makes both boundaries occur repeatedly. A reset asserted in the middle of shifting checks that a partially counted line is abandoned cleanly.

// File: rtl/ccd_clkgen_pkg.sv
package ccd_clkgen_pkg;

  // Position of the line counter within one line
  typedef enum logic [1:0] {
    LP_SETUP = 2'd0,
    LP_GATE  = 2'd1,
    LP_HOLD  = 2'd2,
    LP_SHIFT = 2'd3
  } line_phase_e;

  // One set of sensor drive levels
  typedef struct packed {
    logic shift_a;
    logic gate;
    logic nrst;
    logic clamp;
  } drive_t;

  localparam drive_t DRIVE_PARKED = '{shift_a: 1'b1, gate: 1'b0, nrst: 1'b0, clamp: 1'b0};

endpackage

// File: rtl/ccd_clkgen_line_seq.sv
module ccd_clkgen_line_seq
  import ccd_clkgen_pkg::*;
#(
  parameter int LINE_CLKS  = 110000,
  parameter int SETUP_CLKS = 2,
  parameter int GATE_CLKS  = 100,
  parameter int HOLD_CLKS  = 38
) (
  input  logic        clk,
  input  logic        rst_n,
  output line_phase_e phase,
  output logic        pix_restart
);
  localparam int LW      = $clog2(LINE_CLKS);
  localparam int GATE_AT = SETUP_CLKS;
  localparam int HOLD_AT = SETUP_CLKS + GATE_CLKS;
  localparam int WIN     = SETUP_CLKS + GATE_CLKS + HOLD_CLKS;

  logic [LW-1:0] pos;
  logic          pos_last;

  assign pos_last = (pos == LW'(LINE_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        pos <= '0;
    else if (pos_last) pos <= '0;
    else               pos <= pos + 1'b1;
  end

  always_comb begin
    if (int'(pos) < GATE_AT)      phase = LP_SETUP;
    else if (int'(pos) < HOLD_AT) phase = LP_GATE;
    else if (int'(pos) < WIN)     phase = LP_HOLD;
    else                          phase = LP_SHIFT;
  end

  // the pixel timer restarts so that its offset 0 lands on the first shift cycle
  assign pix_restart = (pos == LW'(WIN - 1));

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < LINE_CLKS);

  // R3
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pos_last) && $past(rst_n) |-> pos == '0);

endmodule

// File: rtl/ccd_clkgen_subpulse.sv
module ccd_clkgen_subpulse #(
  parameter int PW       = 5,
  parameter int START_AT = 12,
  parameter int LEN      = 1
) (
  input  logic [PW-1:0] offset,
  output logic          pulse
);
  localparam int STOP_AT = START_AT + LEN;

  assign pulse = (int'(offset) >= START_AT) && (int'(offset) < STOP_AT);

endmodule

// File: rtl/ccd_clkgen_pix_timer.sv
module ccd_clkgen_pix_timer #(
  parameter int PIX_CLKS = 20,
  parameter int NUM_PIX  = 5415,
  parameter int RST_AT   = 12,
  parameter int RST_LEN  = 1,
  parameter int CLP_AT   = 14,
  parameter int CLP_LEN  = 2,
  localparam int NW      = $clog2(NUM_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          shift_a,
  output logic          nrst,
  output logic          clamp,
  output logic          valid,
  output logic          first,
  output logic [NW-1:0] idx
);
  localparam int PW   = $clog2(PIX_CLKS);
  localparam int HALF = PIX_CLKS / 2;
  localparam int NP   = 2;
  localparam int P_AT  [NP] = '{RST_AT, CLP_AT};
  localparam int P_LEN [NP] = '{RST_LEN, CLP_LEN};

  logic [PW-1:0] ofs;
  logic [NW-1:0] pnum;
  logic          ofs_last;
  logic [NP-1:0] pulses;

  assign ofs_last = (ofs == PW'(PIX_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs  <= '0;
      pnum <= NW'(NUM_PIX);
    end else if (restart) begin
      ofs  <= '0;
      pnum <= '0;
    end else begin
      ofs <= ofs_last ? '0 : ofs + 1'b1;
      if (ofs_last && (pnum != NW'(NUM_PIX))) pnum <= pnum + 1'b1;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_sub
    ccd_clkgen_subpulse #(
      .PW      (PW),
      .START_AT(P_AT[g]),
      .LEN     (P_LEN[g])
    ) u_sub (
      .offset(ofs),
      .pulse (pulses[g])
    );
  end

  assign shift_a = (int'(ofs) < HALF);
  assign nrst    = pulses[0];
  assign clamp   = pulses[1];
  assign valid   = (pnum != NW'(NUM_PIX));
  assign idx     = valid ? pnum + 1'b1 : '0;
  assign first   = valid && (pnum == '0) && (ofs == '0);

  // R7
  sub_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nrst && clamp));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(valid) && $past(rst_n) && !$past(restart) |->
      (idx == $past(idx)) || (idx == $past(idx) + 1'b1));

  // R6
  nrst_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrst |-> !shift_a);

endmodule

// File: rtl/ccd_clkgen.sv
module ccd_clkgen
  import ccd_clkgen_pkg::*;
#(
  parameter int PIX_CLKS   = 20,
  parameter int NUM_PIX    = 5415,
  parameter int SETUP_CLKS = 2,
  parameter int GATE_CLKS  = 100,
  parameter int HOLD_CLKS  = 38,
  parameter int LINE_CLKS  = 110000,
  parameter int RST_AT     = 12,
  parameter int RST_LEN    = 1,
  parameter int CLP_AT     = 14,
  parameter int CLP_LEN    = 2,
  localparam int NW        = $clog2(NUM_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          shift_a,
  output logic          shift_b,
  output logic          xfer_gate,
  output logic          node_rst,
  output logic          clamp,
  output logic          line_start,
  output logic          pixel_valid,
  output logic [NW-1:0] pixel_index
);
  localparam int WIN  = SETUP_CLKS + GATE_CLKS + HOLD_CLKS;
  localparam int HALF = PIX_CLKS / 2;

  // parameter sanity: timing gaps, line fit, sub-pulse placement
  if (PIX_CLKS < 4 || SETUP_CLKS < 1 || GATE_CLKS < 1 || HOLD_CLKS < 1) begin : g_bad_gap
    $error("ccd_clkgen: pixel period or window gap too short");
  end
  if (LINE_CLKS < WIN + NUM_PIX * PIX_CLKS || ((LINE_CLKS - WIN) % PIX_CLKS) != 0) begin : g_bad_line
    $error("ccd_clkgen: line period too short or not a whole number of pixels");
  end
  if (RST_LEN < 1 || CLP_LEN < 1 || RST_AT < 1 || RST_AT + RST_LEN > CLP_AT ||
      CLP_AT + CLP_LEN > PIX_CLKS) begin : g_bad_order
    $error("ccd_clkgen: reset and clamp pulses overlap or leave the pixel");
  end
  if (!((RST_AT + RST_LEN <= HALF) || (RST_AT > HALF)) ||
      !((CLP_AT + CLP_LEN <= HALF) || (CLP_AT > HALF))) begin : g_bad_edge
    $error("ccd_clkgen: a sub-pulse straddles a shift clock edge");
  end

  line_phase_e   phase;
  logic          pix_restart;
  logic          t_shift, t_nrst, t_clamp, t_valid, t_first;
  logic [NW-1:0] t_idx;
  drive_t        drv_d, drv_q;
  logic          in_shift;

  ccd_clkgen_line_seq #(
    .LINE_CLKS (LINE_CLKS),
    .SETUP_CLKS(SETUP_CLKS),
    .GATE_CLKS (GATE_CLKS),
    .HOLD_CLKS (HOLD_CLKS)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .pix_restart(pix_restart)
  );

  ccd_clkgen_pix_timer #(
    .PIX_CLKS(PIX_CLKS),
    .NUM_PIX (NUM_PIX),
    .RST_AT  (RST_AT),
    .RST_LEN (RST_LEN),
    .CLP_AT  (CLP_AT),
    .CLP_LEN (CLP_LEN)
  ) u_pix (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(pix_restart),
    .shift_a(t_shift),
    .nrst   (t_nrst),
    .clamp  (t_clamp),
    .valid  (t_valid),
    .first  (t_first),
    .idx    (t_idx)
  );

  assign in_shift = (phase == LP_SHIFT);

  always_comb begin
    drv_d      = DRIVE_PARKED;
    drv_d.gate = (phase == LP_GATE);
    if (in_shift) begin
      drv_d.shift_a = t_shift;
      drv_d.nrst    = t_nrst;
      drv_d.clamp   = t_clamp;
    end
  end

  // glitch-free registered drive outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q       <= DRIVE_PARKED;
      shift_b     <= 1'b0;
      line_start  <= 1'b0;
      pixel_valid <= 1'b0;
      pixel_index <= '0;
    end else begin
      drv_q       <= drv_d;
      shift_b     <= ~drv_d.shift_a;
      line_start  <= in_shift && t_first;
      pixel_valid <= in_shift && t_valid;
      pixel_index <= in_shift ? t_idx : '0;
    end
  end

  assign shift_a   = drv_q.shift_a;
  assign xfer_gate = drv_q.gate;
  assign node_rst  = drv_q.nrst;
  assign clamp     = drv_q.clamp;

  // R4
  gate_parks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> shift_a && !node_rst && !clamp);

  // R8
  gate_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> !pixel_valid);

  // R10
  start_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pixel_valid && (pixel_index == NW'(1)));

  // R2
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_b == !shift_a);

  // R3
  gate_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_gate) |-> $past(shift_a) && !$past(pixel_valid));

endmodule

// File: tb/ccd_clkgen_tb.sv
module ccd_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX   = 8;
  localparam int NPIX  = 10;
  localparam int SETUP = 2;
  localparam int GATE  = 6;
  localparam int HOLD  = 8;
  localparam int WIN   = SETUP + GATE + HOLD;
  localparam int LINE  = WIN + NPIX * PIX + 2 * PIX;
  localparam int RSA = 5, RSL = 1, CLA = 6, CLL = 1;
  localparam int NW  = $clog2(NPIX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa, sb, gt, nr, cl, ls, pv;
  logic [NW-1:0] pidx;

  int n_chk = 0, n_fail = 0, k = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_clkgen #(
    .PIX_CLKS(PIX), .NUM_PIX(NPIX), .SETUP_CLKS(SETUP), .GATE_CLKS(GATE),
    .HOLD_CLKS(HOLD), .LINE_CLKS(LINE), .RST_AT(RSA), .RST_LEN(RSL),
    .CLP_AT(CLA), .CLP_LEN(CLL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_a(sa), .shift_b(sb), .xfer_gate(gt),
    .node_rst(nr), .clamp(cl), .line_start(ls), .pixel_valid(pv), .pixel_index(pidx)
  );

  typedef struct {
    bit sa, gt, nr, cl, pv, ls;
    int idx;
  } exp_t;

  function automatic exp_t model(int c);
    exp_t e;
    int s, p, n;
    e = '{sa: 1, gt: 0, nr: 0, cl: 0, pv: 0, ls: 0, idx: 0};
    if (c >= SETUP && c < SETUP + GATE) e.gt = 1;
    if (c >= WIN) begin
      s = c - WIN; p = s % PIX; n = s / PIX;
      e.sa = (p < PIX / 2);
      e.nr = (p >= RSA && p < RSA + RSL);
      e.cl = (p >= CLA && p < CLA + CLL);
      e.pv = (n < NPIX);
      e.idx = e.pv ? n + 1 : 0;
      e.ls = (s == 0);
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); k++; #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; k = 0;
  endtask

  // compare every output with the model over n cycles
  task automatic compare_span(int n, int e_ls, int e_gate, int e_pv);
    int m_sa = 0, m_sb = 0, m_gt = 0, m_sub = 0, m_pv = 0, m_idx = 0;
    int c_ls = 0, c_gt = 0, c_pv = 0;
    exp_t e;
    for (int i = 0; i < n; i++) begin
      step();
      e = model((k - 1) % LINE);
      if (sa !== e.sa) m_sa++;
      if (sb !== !sa) m_sb++;
      if (gt !== e.gt) m_gt++;
      if (nr !== e.nr || cl !== e.cl) m_sub++;
      if (pv !== e.pv || ls !== e.ls) m_pv++;
      if (int'(pidx) != e.idx) m_idx++;
      c_ls += int'(ls); c_gt += int'(gt); c_pv += int'(pv);
    end
    chk(m_sa == 0, "R4/R5 shift_a mismatches", m_sa, 0);
    chk(m_sb == 0, "R2 shift_b not complement", m_sb, 0);
    chk(m_gt == 0, "R3 gate mismatches", m_gt, 0);
    chk(m_sub == 0, "R6/R7 node_rst/clamp mismatches", m_sub, 0);
    chk(m_pv == 0, "R8/R10 valid/start mismatches", m_pv, 0);
    chk(m_idx == 0, "R9 pixel_index mismatches", m_idx, 0);
    if (e_ls >= 0)   chk(c_ls == e_ls, "R10 line_start count", c_ls, e_ls);
    if (e_gate >= 0) chk(c_gt == e_gate, "R3 gate high cycles", c_gt, e_gate);
    if (e_pv >= 0)   chk(c_pv == e_pv, "R8 valid cycles", c_pv, e_pv);
  endtask

  task automatic t_reset_state();
    @(posedge clk); #1;
    chk(sa === 1'b1 && sb === 1'b0, "R1 shift clocks in reset", {sa, sb}, 2);
    chk({gt, nr, cl, ls, pv} === 5'b0, "R1 pulses in reset", {gt, nr, cl, ls, pv}, 0);
    chk(pidx === '0, "R1 pixel_index in reset", int'(pidx), 0);
  endtask

  task automatic t_window();
    // R4 window, R3 gate once
    compare_span(WIN, 0, GATE, 0);
  endtask

  task automatic t_shift_line();
    // R5 R6 R7 R8 R9 R10 through the rest of line 1 including the tail
    compare_span(LINE - WIN, 1, 0, NPIX * PIX);
  endtask

  task automatic t_repeat_lines();
    // R3 period: two more whole lines
    compare_span(2 * LINE, 2, 2 * GATE, 2 * NPIX * PIX);
  endtask

  task automatic t_mid_reset();
    compare_span(WIN + 3 * PIX + 3, -1, -1, -1);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    // R11 R1: reset wins on the first edge
    chk(sa === 1'b1 && pv === 1'b0 && pidx === '0, "R11 outputs after mid-line reset",
        {sa, pv}, 2);
    @(negedge clk); rst_n = 1'b1; k = 0;
    // R11 line restarts from the setup gap
    compare_span(LINE, 1, GATE, NPIX * PIX);
  endtask

  initial begin
    do_reset();
    rst_n = 1'b0;
    t_reset_state();
    @(negedge clk); rst_n = 1'b1; k = 0;
    t_window();
    t_shift_line();
    t_repeat_lines();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule